// File: doc/BRIEF.md
# Zero-Cross Status Clear-on-Read Register

This block holds the interrupt status seen by software for an AC line zero-crossing detector and for a periodic interrupt source. A one-cycle pulse from the detector sets a sticky flag. A read of the status register returns that flag in its top bit, together with seven low bits that software stored earlier. The same read also clears the flag. A saturating counter tracks periodic illumination interrupt ticks. It is zeroed only when a status read actually consumes a set flag. A second register tells the fast-interrupt handler whether the interrupt came from the display or from the timer.

Accesses are single cycle. The register number is decoded while `rd_en` or `wr_en` is high, and read data is captured into `rd_data` on the same clock edge. `rd_data` then holds that value until the next read. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `zc_status_top`

## Requirements
- R1: After reset, `rd_data` is 0x00, the sticky flag is clear, the stored low bits are zero and `gi_count` is zero.
- R2: A read of register 0 captures into `rd_data` the sticky flag in bit 7 and the stored low bits in bits 6:0, using their values before the edge.
- R3: Every read of register 0 clears the sticky flag, so the next read of register 0 shows bit 7 low unless a new pulse has arrived.
- R4: A read of register 0 with the flag set zeroes `gi_count`. A read with the flag clear leaves `gi_count` unchanged.
- R5: A `zc_pulse` in the same cycle as a clearing read leaves the flag set afterwards. The read itself returns the flag value from before that pulse.
- R6: Each `gi_tick` cycle raises `gi_count` by one. The count saturates at 2^CNT_W-1.
- R7: A read of register 1 returns 0x00 when `firq_from_disp` is high, and otherwise returns the parameter FIRQ_CLR (default 0x80).
- R8: A write to register 0 stores `wr_data[6:0]` as the low bits. Bit 7 of the write has no effect on the flag.
- R9: Reads of registers 2 and 3 return 0x00. Writes to them change neither the flag, the low bits nor `gi_count`.
- R10: If a `gi_tick` coincides with a read that consumes a set flag, `gi_count` becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | ADDR_W | Register number for the access |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Captured read data |
| zc_pulse | input | 1 | Zero-crossing event pulse |
| gi_tick | input | 1 | Periodic illumination interrupt tick |
| firq_from_disp | input | 1 | High when the fast interrupt came from the display |
| gi_count | output | CNT_W | Illumination interrupt count |

## Verification
The assertions assume that the event and strobe inputs are synchronous to `clk` and stable around the rising edge. They also assume that `zc_pulse` and `gi_tick` mark one event for each high cycle. The bench drives every input on the falling edge and holds it for one full cycle, so each high level is sampled exactly once. Read and write may be raised together. In that case the read returns the low bits from before the write, and the bench model follows the same rule.

// File: rtl/zc_pkg.sv
package zc_pkg;
  localparam int DATA_W   = 8;
  localparam int FLAG_BIT = DATA_W - 1;
  localparam int LOW_W    = DATA_W - 1;
  typedef logic [DATA_W-1:0] reg_word_t;
  typedef logic [LOW_W-1:0]  low_bits_t;
endpackage

// File: rtl/zc_rst_sync.sv
module zc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/zc_sticky_flag.sv
module zc_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_rd,
  output logic flag
);
  logic flag_d;

  always_comb begin
    flag_d = flag;
    if (clr_rd)  flag_d = 1'b0;
    if (set_evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end

  assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && !set_evt) |=> !flag);
  assert_pulse_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_rd && !set_evt) |=> $stable(flag));
endmodule

// File: rtl/zc_gi_counter.sv
module zc_gi_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    count_en = clr || (tick && (count != CNT_MAX));
    count_d  = clr ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_d;
  end

  assert_cnt_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  assert_cnt_zero_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && tick) |=> (count == '0));
  assert_cnt_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && count == CNT_MAX) |=> (count == CNT_MAX));
  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && tick && count != CNT_MAX) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/zc_status_top.sv
module zc_status_top
  import zc_pkg::*;
#(
  parameter int              ADDR_W    = 2,
  parameter int              CNT_W     = 8,
  parameter logic [ADDR_W-1:0] ZC_REG   = 0,
  parameter logic [ADDR_W-1:0] FIRQ_REG = 1,
  parameter logic [7:0]      FIRQ_CLR  = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              zc_pulse,
  input  logic              gi_tick,
  input  logic              firq_from_disp,
  output logic [CNT_W-1:0]  gi_count
);
  logic      rst_n_i;
  logic      zc_flag;
  low_bits_t low_q;
  reg_word_t rd_d;
  logic      zc_rd;
  logic      zc_wr;
  logic      gi_clr;
  logic      unused_wr_msb;

  assign unused_wr_msb = wr_data[FLAG_BIT];

  zc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  assign zc_rd  = rd_en && (reg_sel == ZC_REG);
  assign zc_wr  = wr_en && (reg_sel == ZC_REG);
  assign gi_clr = zc_rd && zc_flag;

  zc_sticky_flag i_flag (
    .clk(clk), .rst_n(rst_n_i), .set_evt(zc_pulse), .clr_rd(zc_rd), .flag(zc_flag)
  );

  zc_gi_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n_i), .tick(gi_tick), .clr(gi_clr), .count(gi_count)
  );

  always_comb begin
    case (reg_sel)
      ZC_REG:   rd_d = {zc_flag, low_q};
      FIRQ_REG: rd_d = firq_from_disp ? 8'h00 : FIRQ_CLR;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)   low_q <= '0;
    else if (zc_wr) low_q <= wr_data[LOW_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)   rd_data <= '0;
    else if (rd_en) rd_data <= rd_d;
  end

  assert_firq_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_en && reg_sel == FIRQ_REG) |=>
      (rd_data == ($past(firq_from_disp) ? 8'h00 : FIRQ_CLR)));
  assert_zc_read_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_en && reg_sel == ZC_REG) |=> (rd_data[FLAG_BIT] == $past(zc_flag)));
  assert_low_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    !zc_wr |=> $stable(low_q));
  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_en && reg_sel != ZC_REG && reg_sel != FIRQ_REG) |=> (rd_data == 8'h00));
  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/test_zc_status_top.sv
`timescale 1ns/1ps
module test_zc_status_top;
  localparam int CNT_W = 8;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_sel = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       zc_pulse = 1'b0, gi_tick = 1'b0, firq_from_disp = 1'b0;
  logic [CNT_W-1:0] gi_count;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  int m_flag = 0, m_low = 0, m_cnt = 0, m_rd = 0;

  always #2.5 clk = ~clk;

  zc_status_top #(.CNT_W(CNT_W)) i_zc_status_top (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .zc_pulse(zc_pulse), .gi_tick(gi_tick),
    .firq_from_disp(firq_from_disp), .gi_count(gi_count)
  );

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=0x%0h expected=0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // one access cycle; inputs driven at negedge, results sampled at next negedge
  task automatic step(bit rd, bit wr, int sel, int wd, bit zc, bit tk, bit disp,
                      string req);
    int exp_rd;
    rd_en = rd; wr_en = wr; reg_sel = sel[1:0]; wr_data = wd[7:0];
    zc_pulse = zc; gi_tick = tk; firq_from_disp = disp;
    if (sel == 0)      exp_rd = (m_flag << 7) | m_low;
    else if (sel == 1) exp_rd = disp ? 0 : 8'h80;
    else               exp_rd = 0;
    if (rd) m_rd = exp_rd;
    if (rd && sel == 0 && m_flag == 1) m_cnt = 0;
    else if (tk && m_cnt != CMAX) m_cnt = m_cnt + 1;
    if (rd && sel == 0) m_flag = 0;
    if (zc) m_flag = 1;
    if (wr && sel == 0) m_low = wd & 8'h7f;
    @(negedge clk);
    rd_en = 0; wr_en = 0; zc_pulse = 0; gi_tick = 0;
    chk(req, rd_data, m_rd);
    chk(req, gi_count, m_cnt);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired got=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", rd_data, 0);
    chk("R1", gi_count, 0);
    step(1, 0, 0, 0, 0, 0, 0, "R1");
    // R9: unmapped reads and writes
    step(0, 1, 2, 8'h55, 0, 0, 0, "R9");
    step(1, 0, 2, 0, 0, 0, 0, "R9");
    step(0, 1, 3, 8'hff, 0, 0, 0, "R9");
    step(1, 0, 3, 0, 0, 0, 0, "R9");
    step(1, 0, 0, 0, 0, 0, 0, "R9");
    // R7: fast interrupt source
    step(1, 0, 1, 0, 0, 0, 1, "R7");
    step(1, 0, 1, 0, 0, 0, 0, "R7");
    // R8 + R2: sweep all write values, bit 7 must not reach the flag
    for (int v = 0; v < 256; v++) begin
      step(0, 1, 0, v, 0, 0, 0, "R8");
      step(1, 0, 0, 0, 0, 0, 0, "R8");
    end
    // R6: count to saturation and beyond
    for (int i = 0; i < CMAX + 5; i++) step(0, 0, 0, 0, 0, 1, 0, "R6");
    chk("R6", gi_count, CMAX);
    // R4: read with flag clear keeps the count
    step(1, 0, 0, 0, 0, 0, 0, "R4");
    chk("R4", gi_count, CMAX);
    // R2/R3/R4: pulse, read clears flag and count
    step(0, 0, 0, 0, 1, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0, 0, "R3");
    chk("R3", rd_data[7], 1);
    chk("R4", gi_count, 0);
    step(1, 0, 0, 0, 0, 0, 0, "R3");
    chk("R3", rd_data[7], 0);
    // R5: pulse with the clearing read
    step(1, 0, 0, 0, 1, 0, 0, "R5");
    chk("R5", rd_data[7], 0);
    step(1, 0, 0, 0, 0, 0, 0, "R5");
    chk("R5", rd_data[7], 1);
    // R10: tick with a consuming read
    step(0, 0, 0, 0, 0, 1, 0, "R10");
    step(0, 0, 0, 0, 1, 1, 0, "R10");
    step(1, 0, 0, 0, 0, 1, 0, "R10");
    chk("R10", gi_count, 0);
    // near-exhaustive pseudo-random mix against the model
    lfsr = 32'h1ace;
    for (int i = 0; i < 6000; i++) begin
      lfsr = (lfsr << 1) ^ (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1);
      lfsr = lfsr & 16'hffff;
      step(lfsr[0], lfsr[1], lfsr[3:2], lfsr[11:4], lfsr[12], lfsr[13] | lfsr[14],
           lfsr[15], "R2");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule